// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment selection and an offset into a 20-bit physical memory address. It keeps six 16-bit segment registers: one for code, one for stack and four for data. Each request brings an addressing-mode select, the identity of the register that serves as the base, the values of a base and an index register, and a 16-bit displacement. From these the block forms a 16-bit effective address. It then picks a segment, either the default implied by the mode and base register or an explicit override. The physical address is that segment's value shifted left by four bits, plus the effective address.

The address path is purely combinational from the request inputs and the stored segment values. A synchronous write port loads any segment register, and the new value takes effect on the cycle after the write edge. A pipeline stage that computes operand or fetch addresses would use the block once per cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: Six segment registers are indexed 0 = code, 1 = stack, 2..5 = data (2 is the default data segment). All of them reset to 0x0000 while the active-low `rstN` is low.
- R2: When `segWrEn` is high at a rising clock edge and `segWrIdx` is 0..5, that register takes `segWrData`. The new value is used from the next cycle on. A write to index 6 or 7 changes no register.
- R3: `physAddr` equals (selected segment × 16 + `effAddr`) modulo 2^20.
- R4: `effAddr` is computed modulo 2^16 according to the mode: 0 direct = disp; 1 register-indirect = base; 2 base+disp; 3 base+index; 4 base+index+disp; 5 code fetch = base (instruction pointer); 6 stack = base (stack pointer).
- R5: For modes 1 to 4, the default segment is 1 (stack) when `regSel` is 1 (BP) and 2 otherwise. The `regSel` encoding is 0 = BX, 1 = BP, 2 = SI, 3 = DI. For direct mode the default segment is 2.
- R6: Code-fetch mode always uses segment 0. Stack mode defaults to segment 1.
- R7: When `ovrEn` is high and `ovrIdx` is 0..5, `ovrIdx` replaces the default segment in every mode except code fetch. An override index of 6 or 7 has no effect.
- R8: The reserved mode 7 behaves exactly like direct mode.
- R9: `segIdx` reports the segment chosen for the current request and is always 0..5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the segment write port |
| rstN | input | 1 | Asynchronous active-low reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 3 | Segment register to write |
| segWrData | input | 16 | Value to write |
| mode | input | 3 | Addressing mode select |
| regSel | input | 2 | Identity of the base register |
| baseVal | input | 16 | Base register value (or IP/SP) |
| indexVal | input | 16 | Index register value |
| disp | input | 16 | Displacement or direct constant |
| ovrEn | input | 1 | Segment override enable |
| ovrIdx | input | 3 | Override segment index |
| physAddr | output | 20 | Physical address |
| segIdx | output | 3 | Selected segment index |
| effAddr | output | 16 | Effective address |

## Verification
The bench aims at the carry boundaries first. An effective-address sum past 0xFFFF must drop its carry instead of moving into the segment base, and a segment of 0xFFFF plus a large offset must wrap to a low address rather than spill into bit 20. It also tests BP against the other base registers in every register mode, because a design that keys the stack default on the mode alone picks the wrong segment. Other checks cover overrides during code fetch and invalid override or write indices, where a careless design would switch away from CS or corrupt a register. Random requests across all modes then compare the three outputs against a bench model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int SEG_IDX_W = 3;

  typedef enum logic [2:0] {
    MODE_DIRECT        = 3'd0,
    MODE_REG           = 3'd1,
    MODE_BASE_DISP     = 3'd2,
    MODE_BASE_IDX      = 3'd3,
    MODE_BASE_IDX_DISP = 3'd4,
    MODE_CODE          = 3'd5,
    MODE_STACK         = 3'd6,
    MODE_RSVD          = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    REG_BX = 2'd0,
    REG_BP = 2'd1,
    REG_SI = 2'd2,
    REG_DI = 2'd3
  } base_reg_e;

  localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_IDX_W-1:0] SEG_STACK = 3'd1;
  localparam logic [SEG_IDX_W-1:0] SEG_DATA  = 3'd2;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic                 useBase;
    logic                 useIndex;
    logic                 useDisp;
    logic [SEG_IDX_W-1:0] segSel;
  } ea_ctrl_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic [2:0]           mode,
  input  logic [1:0]           regSel,
  input  logic                 ovrEn,
  input  logic [SEG_IDX_W-1:0] ovrIdx,
  output ea_ctrl_t             ctrl
);

  localparam logic [SEG_IDX_W-1:0] SegLimit = SEG_IDX_W'(NUM_SEG);

  addr_mode_e            modeE;
  logic                  bpBased;
  logic                  ovrValid;
  logic [SEG_IDX_W-1:0]  segDefault;

  assign modeE    = addr_mode_e'(mode);
  assign bpBased  = (base_reg_e'(regSel) == REG_BP);
  assign ovrValid = ovrEn && (ovrIdx < SegLimit) && (modeE != MODE_CODE);

  always_comb begin
    ctrl       = '0;
    segDefault = SEG_DATA;
    unique case (modeE)
      MODE_REG: begin
        ctrl.useBase = 1'b1;
        segDefault   = bpBased ? SEG_STACK : SEG_DATA;
      end
      MODE_BASE_DISP: begin
        ctrl.useBase = 1'b1;
        ctrl.useDisp = 1'b1;
        segDefault   = bpBased ? SEG_STACK : SEG_DATA;
      end
      MODE_BASE_IDX: begin
        ctrl.useBase  = 1'b1;
        ctrl.useIndex = 1'b1;
        segDefault    = bpBased ? SEG_STACK : SEG_DATA;
      end
      MODE_BASE_IDX_DISP: begin
        ctrl.useBase  = 1'b1;
        ctrl.useIndex = 1'b1;
        ctrl.useDisp  = 1'b1;
        segDefault    = bpBased ? SEG_STACK : SEG_DATA;
      end
      MODE_CODE: begin
        ctrl.useBase = 1'b1;
        segDefault   = SEG_CODE;
      end
      MODE_STACK: begin
        ctrl.useBase = 1'b1;
        segDefault   = SEG_STACK;
      end
      default: begin
        // direct and reserved: constant only
        ctrl.useDisp = 1'b1;
        segDefault   = SEG_DATA;
      end
    endcase
    ctrl.segSel = ovrValid ? ovrIdx : segDefault;
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   segWrEn,
  input  logic [SEG_IDX_W-1:0]   segWrIdx,
  input  logic [SEG_W-1:0]       segWrData,
  input  logic [SEG_W-1:0]       baseVal,
  input  logic [SEG_W-1:0]       indexVal,
  input  logic [SEG_W-1:0]       disp,
  input  ea_ctrl_t               ctrl,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [SEG_W-1:0]       effAddr
);

  localparam int PHYS_W = SEG_W + SHIFT;

  logic [SEG_W-1:0] segRegs [NUM_SEG];
  logic [SEG_W-1:0] segVal;
  logic [SEG_W-1:0] baseTerm, indexTerm, dispTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) segRegs[i] <= '0;
    end else if (segWrEn) begin
      for (int i = 0; i < NUM_SEG; i++)
        if (segWrIdx == SEG_IDX_W'(i)) segRegs[i] <= segWrData;
    end
  end

  always_comb begin
    segVal = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (ctrl.segSel == SEG_IDX_W'(i)) segVal = segRegs[i];
  end

  assign baseTerm  = ctrl.useBase  ? baseVal  : '0;
  assign indexTerm = ctrl.useIndex ? indexVal : '0;
  assign dispTerm  = ctrl.useDisp  ? disp     : '0;

  // 16-bit sum drops carries before the segment base is added
  assign effAddr  = baseTerm + indexTerm + dispTerm;
  assign physAddr = {segVal, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, effAddr};

  if (PHYS_W <= SEG_W) begin : g_bad_width
    initial $error("segment shift must be positive");
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   segWrEn,
  input  logic [2:0]             segWrIdx,
  input  logic [SEG_W-1:0]       segWrData,
  input  logic [2:0]             mode,
  input  logic [1:0]             regSel,
  input  logic [SEG_W-1:0]       baseVal,
  input  logic [SEG_W-1:0]       indexVal,
  input  logic [SEG_W-1:0]       disp,
  input  logic                   ovrEn,
  input  logic [2:0]             ovrIdx,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [2:0]             segIdx,
  output logic [SEG_W-1:0]       effAddr
);

  ea_ctrl_t ctrl;

  seg_addr_ctrl #(.NUM_SEG(NUM_SEG)) i_ctrl (
    .mode   (mode),
    .regSel (regSel),
    .ovrEn  (ovrEn),
    .ovrIdx (ovrIdx),
    .ctrl   (ctrl)
  );

  seg_addr_dp #(.SEG_W(SEG_W), .SHIFT(SHIFT), .NUM_SEG(NUM_SEG)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .segWrEn   (segWrEn),
    .segWrIdx  (segWrIdx),
    .segWrData (segWrData),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .disp      (disp),
    .ctrl      (ctrl),
    .physAddr  (physAddr),
    .effAddr   (effAddr)
  );

  assign segIdx = ctrl.segSel;

endmodule

// File: rtl/seg_addr_checker.sv
module seg_addr_checker #(
  parameter int SEG_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   segWrEn,
  input logic [2:0]             segWrIdx,
  input logic [SEG_W-1:0]       segWrData,
  input logic [2:0]             mode,
  input logic [1:0]             regSel,
  input logic                   ovrEn,
  input logic [2:0]             ovrIdx,
  input logic [SEG_W+SHIFT-1:0] physAddr,
  input logic [2:0]             segIdx,
  input logic [SEG_W-1:0]       effAddr
);

  localparam logic [2:0] SegLimit = 3'(NUM_SEG);

  a_r9_index_range: assert property (@(posedge clk) disable iff (!rstN)
    segIdx < SegLimit);

  a_r6_code_segment: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd5 |-> segIdx == 3'd0);

  a_r5_bp_stack_default: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrEn && mode >= 3'd1 && mode <= 3'd4 && regSel == 2'd1) |-> segIdx == 3'd1);

  a_r7_override_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ovrEn && ovrIdx < SegLimit && mode != 3'd5) |-> segIdx == ovrIdx);

  // R2 and R3: a written segment shows up as the base on the next cycle
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segWrIdx < SegLimit) |=>
      ((segIdx != $past(segWrIdx)) ||
       ((physAddr - {{SHIFT{1'b0}}, effAddr}) == {$past(segWrData), {SHIFT{1'b0}}})));

endmodule

bind seg_addr_gen seg_addr_checker #(.SEG_W(SEG_W), .SHIFT(SHIFT), .NUM_SEG(NUM_SEG)) i_chk (.*);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [2:0]  segWrIdx = '0;
  logic [15:0] segWrData = '0;
  logic [2:0]  mode = '0;
  logic [1:0]  regSel = '0;
  logic [15:0] baseVal = '0, indexVal = '0, disp = '0;
  logic        ovrEn = 1'b0;
  logic [2:0]  ovrIdx = '0;
  logic [19:0] physAddr;
  logic [2:0]  segIdx;
  logic [15:0] effAddr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [6];

  always #2.5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (.*);

  function automatic logic [15:0] expEa(logic [2:0] m, logic [15:0] b, logic [15:0] x, logic [15:0] d);
    case (m)
      3'd1, 3'd5, 3'd6: return b;
      3'd2: return b + d;
      3'd3: return b + x;
      3'd4: return b + x + d;
      default: return d;
    endcase
  endfunction

  function automatic logic [2:0] expSeg(logic [2:0] m, logic [1:0] r, logic oe, logic [2:0] oi);
    logic [2:0] s;
    case (m)
      3'd5: s = 3'd0;
      3'd6: s = 3'd1;
      3'd1, 3'd2, 3'd3, 3'd4: s = (r == 2'd1) ? 3'd1 : 3'd2;
      default: s = 3'd2;
    endcase
    if (oe && oi < 3'd6 && m != 3'd5) s = oi;
    return s;
  endfunction

  task automatic writeSeg(logic [2:0] idx, logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = val;
    @(posedge clk); #1;
    segWrEn = 1'b0;
    if (idx < 3'd6) model[idx] = val;
  endtask

  task automatic lookup(string tag, logic [2:0] m, logic [1:0] r, logic [15:0] b,
                        logic [15:0] x, logic [15:0] d, logic oe, logic [2:0] oi);
    logic [15:0] ea;
    logic [2:0]  sg;
    logic [19:0] pa;
    @(negedge clk);
    mode = m; regSel = r; baseVal = b; indexVal = x; disp = d; ovrEn = oe; ovrIdx = oi;
    #1;
    ea = expEa(m, b, x, d);
    sg = expSeg(m, r, oe, oi);
    pa = {model[sg], 4'h0} + {4'h0, ea};
    checks++;
    if (effAddr !== ea || segIdx !== sg || physAddr !== pa) begin
      fails++;
      $display("FAIL %s: got ea=%h seg=%0d pa=%h, expected ea=%h seg=%0d pa=%h",
               tag, effAddr, segIdx, physAddr, ea, sg, pa);
    end
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2013));
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset leaves every segment at zero
    for (int s = 0; s < 6; s++) lookup("R1 reset zero", 3'd0, 2'd0, 16'h0, 16'h0, 16'h1234, 1'b1, 3'(s));

    // R2: load distinct values into all segments
    writeSeg(3'd0, 16'hF000); writeSeg(3'd1, 16'h2000); writeSeg(3'd2, 16'h3000);
    writeSeg(3'd3, 16'h4000); writeSeg(3'd4, 16'h5000); writeSeg(3'd5, 16'h6000);
    for (int s = 0; s < 6; s++) lookup("R2 write visible", 3'd0, 2'd0, 16'h0, 16'h0, 16'h0010, 1'b1, 3'(s));
    writeSeg(3'd6, 16'hAAAA); writeSeg(3'd7, 16'h5555);
    for (int s = 0; s < 6; s++) lookup("R2 bad index ignored", 3'd0, 2'd0, 16'h0, 16'h0, 16'h0, 1'b1, 3'(s));

    // R4: effective-address wrap
    lookup("R4 ea wrap", 3'd4, 2'd0, 16'hFFF0, 16'h0020, 16'h0001, 1'b0, 3'd0);
    lookup("R4 base disp", 3'd2, 2'd2, 16'h8000, 16'h0, 16'h8001, 1'b0, 3'd0);
    // R3: physical wrap
    writeSeg(3'd2, 16'hFFFF);
    lookup("R3 phys wrap", 3'd0, 2'd0, 16'h0, 16'h0, 16'h0010, 1'b0, 3'd0);
    lookup("R3 phys top", 3'd0, 2'd0, 16'h0, 16'h0, 16'h000F, 1'b0, 3'd0);
    // R5: BP versus other bases
    for (int m = 1; m <= 4; m++)
      for (int r = 0; r < 4; r++)
        lookup("R5 base default", 3'(m), 2'(r), 16'h1111, 16'h0202, 16'h0033, 1'b0, 3'd0);
    // R6: code and stack
    lookup("R6 code fetch", 3'd5, 2'd1, 16'h0100, 16'h0, 16'h0, 1'b0, 3'd0);
    lookup("R6 stack", 3'd6, 2'd0, 16'hFFFE, 16'h0, 16'h0, 1'b0, 3'd0);
    // R7: overrides
    lookup("R7 override ES", 3'd1, 2'd1, 16'h0042, 16'h0, 16'h0, 1'b1, 3'd3);
    lookup("R7 code ignores override", 3'd5, 2'd0, 16'h0042, 16'h0, 16'h0, 1'b1, 3'd4);
    lookup("R7 override idx 6 ignored", 3'd3, 2'd1, 16'h0042, 16'h1, 16'h0, 1'b1, 3'd6);
    lookup("R7 override idx 7 ignored", 3'd0, 2'd0, 16'h0, 16'h0, 16'h0042, 1'b1, 3'd7);
    // R8: reserved mode
    lookup("R8 reserved as direct", 3'd7, 2'd1, 16'h7777, 16'h8888, 16'h0123, 1'b0, 3'd0);

    // R9 and mixed: random requests and writes
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 7) == 0) writeSeg(3'($urandom_range(0, 7)), 16'($urandom));
      lookup("R9 random", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 16'($urandom),
             16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule